// File: doc/BRIEF.md
# LPC Shutdown and Reset Controller

This block decides which reset or shutdown level an LPC host-interface slave is in, and applies the side effects of that level. It watches a synchronous system reset and two host-side pins: the LPC reset pin and the power-down pin, both active low and asynchronous. It also holds a small control word that software writes: a software reset bit, a shutdown enable bit, a software shutdown bit, a set of channel enables and a set of optional-pin enables. Each level clears its own subset of those bits. The block also tells the pad ring which host pins to float.

Five levels are ranked. From highest to lowest they are system reset, LPC hardware reset, LPC software reset, hardware shutdown and software shutdown. The highest active level wins. In either shutdown level the core bus pins are isolated, and each optional side-band pin is isolated only if its own enable bit is set. The reset pin and the power-down pin have no isolation control, so they keep working in every level. Whenever the level rises between LPC levels, a one-cycle init strobe tells the downstream protocol state machines to clear themselves.

Top module: `lpc_pwrctl`

## Requirements
- R1: While `rst` is 1, the next clock edge clears every bit of the control word, including the channel and optional enables, sets `lvl_state` to 5 and drives `iso_core`, `iso_opt` and `lpc_init` to 0.
- R2: Control word layout: bit 0 is the software reset bit, bit 1 the shutdown enable, bit 2 the software shutdown bit, bits 3 to 5 the channel enables and bits 6 to 9 the optional-pin enables (6 SCI, 7 SMI, 8 PME, 9 gate-A20). A write with `reg_we` high loads `reg_wdata` at the clock edge, and `reg_rdata` shows the word after that edge, except for the bits that the active level clears.
- R3: Both host pins pass through SYNC_STAGES (default 2) flip-flops. A pin change set up before edge k changes `lvl_state` at edge k+2.
- R4: `lvl_state` encodes the active level as 0 normal, 1 software shutdown, 2 hardware shutdown, 3 software reset, 4 hardware reset and 5 system reset. When several levels are active, the highest one is shown.
- R5: While the synchronized `host_rst_n` is low, the level is 4. Bits 0, 1 and 2 are cleared, and the clear wins over a write in the same cycle. Bits 3 to 9 are kept.
- R6: While bit 0 is 1 and no higher level is active, the level is 3. Bits 1 and 2 are cleared, and the clear wins over a write.
- R7: When the synchronized `pwrdn_n` is low and bit 1 is 1 (with no higher level active), the level is 2 and bit 2 is cleared. The level leaves 2 once `pwrdn_n` is high again.
- R8: When bit 2 is 1 and no higher level is active, the level is 1.
- R9: `iso_core` is 1 exactly when `lvl_state` is 1 or 2. It changes at the same edge as `lvl_state`.
- R10: `iso_opt[i]` is 1 exactly when the level entered at that edge is 1 or 2 and optional enable bit 6+i was 1 before that edge. Otherwise it is 0.
- R11: `lpc_init` is 1 for the single cycle after an edge at which the level rises above its previous value. It stays 0 while leaving system reset and under `rst`.
- R12: The host reset pin and the power-down pin keep their effect in every level. A host reset applied during a shutdown moves the level to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous system reset, active high (standby, reset pin or watchdog combined) |
| host_rst_n | input | 1 | Asynchronous LPC hardware reset pin, active low |
| pwrdn_n | input | 1 | Asynchronous LPC power-down pin, active low |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 3+N_CHAN+N_OPT | Control word write data |
| reg_rdata | output | 3+N_CHAN+N_OPT | Current control word |
| lvl_state | output | 3 | Active level code |
| iso_core | output | 1 | Float the address/data, serial IRQ and clock-run pins, and gate the frame and clock inputs |
| iso_opt | output | N_OPT | Float each optional side-band pin |
| lpc_init | output | 1 | One-cycle init strobe for the LPC state machines |

## Verification
Directed phases raise each level alone, then stack levels on top of each other. A host reset arriving during a hardware shutdown shows whether priority and the pin path stay live. Writes to the cleared bits while a level holds them show whether the clear wins over the write. Turning optional enables on and off during a software shutdown separates per-pin isolation from core isolation. A long random phase then toggles both pins, rare system resets and writes with random data, so that all transitions between levels meet the synchronizer latency and the init-strobe rule.

// File: rtl/lpc_pwr_pkg.sv
package lpc_pwr_pkg;

  typedef enum logic [2:0] {
    LVL_RUN    = 3'd0,
    LVL_SWSD   = 3'd1,
    LVL_HWSD   = 3'd2,
    LVL_SWRST  = 3'd3,
    LVL_HWRST  = 3'd4,
    LVL_SYSRST = 3'd5
  } lvl_e;

  localparam int CTL_SWRST = 0;
  localparam int CTL_SDEN  = 1;
  localparam int CTL_SWSD  = 2;
  localparam int CTL_CHAN_LSB = 3;

  function automatic logic lvl_is_shutdown(input lvl_e l);
    return (l == LVL_SWSD) || (l == LVL_HWSD);
  endfunction

endpackage

// File: rtl/lpc_pwr_sync.sv
module lpc_pwr_sync #(
  parameter int WIDTH = 2,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= RST_VAL;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= RST_VAL;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/lpc_pwr_ctlreg.sv
module lpc_pwr_ctlreg
  import lpc_pwr_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we,
  input  logic [W-1:0] wdata,
  input  lvl_e         lvl_d,
  output logic [W-1:0] ctl_q
);

  logic [W-1:0] nxt;

  always_comb begin
    nxt = we ? wdata : ctl_q;
    case (lvl_d)
      LVL_HWRST: begin
        nxt[CTL_SWRST] = 1'b0;
        nxt[CTL_SDEN]  = 1'b0;
        nxt[CTL_SWSD]  = 1'b0;
      end
      LVL_SWRST: begin
        nxt[CTL_SDEN]  = 1'b0;
        nxt[CTL_SWSD]  = 1'b0;
      end
      LVL_HWSD:  nxt[CTL_SWSD] = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) ctl_q <= '0;
    else     ctl_q <= nxt;
  end

endmodule

// File: rtl/lpc_pwr_level.sv
module lpc_pwr_level
  import lpc_pwr_pkg::*;
#(
  parameter int W = 10,
  parameter int N_OPT = 4,
  parameter int OPT_LSB = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     ctl_q,
  input  logic             hwrst_s,
  input  logic             pd_s,
  output lvl_e             lvl_d,
  output lvl_e             state_q,
  output logic             iso_core_q,
  output logic [N_OPT-1:0] iso_opt_q,
  output logic             init_q
);

  logic             shut_d;
  logic [N_OPT-1:0] opt_d;

  always_comb begin
    if (hwrst_s)                      lvl_d = LVL_HWRST;
    else if (ctl_q[CTL_SWRST])        lvl_d = LVL_SWRST;
    else if (pd_s && ctl_q[CTL_SDEN]) lvl_d = LVL_HWSD;
    else if (ctl_q[CTL_SWSD])         lvl_d = LVL_SWSD;
    else                              lvl_d = LVL_RUN;
  end

  assign shut_d = lvl_is_shutdown(lvl_d);

  generate
    for (genvar i = 0; i < N_OPT; i++) begin : g_opt
      assign opt_d[i] = shut_d & ctl_q[OPT_LSB+i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= LVL_SYSRST;
      iso_core_q <= 1'b0;
      iso_opt_q  <= '0;
      init_q     <= 1'b0;
    end else begin
      state_q    <= lvl_d;
      iso_core_q <= shut_d;
      iso_opt_q  <= opt_d;
      init_q     <= (lvl_d > state_q);
    end
  end

endmodule

// File: rtl/lpc_pwrctl.sv
module lpc_pwrctl
  import lpc_pwr_pkg::*;
#(
  parameter int N_CHAN = 3,
  parameter int N_OPT = 4,
  parameter int SYNC_STAGES = 2,
  localparam int W = 3 + N_CHAN + N_OPT,
  localparam int OPT_LSB = CTL_CHAN_LSB + N_CHAN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_rst_n,
  input  logic             pwrdn_n,
  input  logic             reg_we,
  input  logic [W-1:0]     reg_wdata,
  output logic [W-1:0]     reg_rdata,
  output logic [2:0]       lvl_state,
  output logic             iso_core,
  output logic [N_OPT-1:0] iso_opt,
  output logic             lpc_init
);

  logic [1:0] pins_s;
  logic [W-1:0] ctl_q;
  lvl_e lvl_d;
  lvl_e state_q;

  lpc_pwr_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst(rst), .d({pwrdn_n, host_rst_n}), .q(pins_s)
  );

  lpc_pwr_ctlreg #(.W(W)) u_ctl (
    .clk(clk), .rst(rst), .we(reg_we), .wdata(reg_wdata),
    .lvl_d(lvl_d), .ctl_q(ctl_q)
  );

  lpc_pwr_level #(.W(W), .N_OPT(N_OPT), .OPT_LSB(OPT_LSB)) u_lvl (
    .clk(clk), .rst(rst), .ctl_q(ctl_q),
    .hwrst_s(~pins_s[0]), .pd_s(~pins_s[1]),
    .lvl_d(lvl_d), .state_q(state_q),
    .iso_core_q(iso_core), .iso_opt_q(iso_opt), .init_q(lpc_init)
  );

  assign reg_rdata = ctl_q;
  assign lvl_state = state_q;

endmodule

// File: rtl/lpc_pwrctl_chk.sv
module lpc_pwrctl_chk #(
  parameter int N_CHAN = 3,
  parameter int N_OPT = 4,
  localparam int W = 3 + N_CHAN + N_OPT
) (
  input logic             clk,
  input logic             rst,
  input logic [W-1:0]     reg_rdata,
  input logic [2:0]       lvl_state,
  input logic             iso_core,
  input logic [N_OPT-1:0] iso_opt,
  input logic             lpc_init
);

  a_r1_sysrst_clears: assert property (@(posedge clk)
    rst |=> (reg_rdata == '0 && lvl_state == 3'd5 && !iso_core && iso_opt == '0 && !lpc_init));

  a_r4_state_legal: assert property (@(posedge clk) disable iff (rst)
    lvl_state <= 3'd5);

  a_r5_hwrst_bits: assert property (@(posedge clk) disable iff (rst)
    (lvl_state == 3'd4) |-> (reg_rdata[2:0] == 3'b000));

  a_r6_swrst_bits: assert property (@(posedge clk) disable iff (rst)
    (lvl_state == 3'd3) |-> (reg_rdata[2:1] == 2'b00));

  a_r7_hwsd_bit: assert property (@(posedge clk) disable iff (rst)
    (lvl_state == 3'd2) |-> !reg_rdata[2]);

  a_r9_iso_level: assert property (@(posedge clk) disable iff (rst)
    iso_core == (lvl_state == 3'd1 || lvl_state == 3'd2));

  a_r10_opt_within_core: assert property (@(posedge clk) disable iff (rst)
    (iso_opt != '0) |-> iso_core);

  a_r11_init_on_rise: assert property (@(posedge clk) disable iff (rst)
    lpc_init |-> (lvl_state > $past(lvl_state)));

endmodule

bind lpc_pwrctl lpc_pwrctl_chk #(.N_CHAN(N_CHAN), .N_OPT(N_OPT)) u_chk (
  .clk(clk), .rst(rst), .reg_rdata(reg_rdata), .lvl_state(lvl_state),
  .iso_core(iso_core), .iso_opt(iso_opt), .lpc_init(lpc_init)
);

// File: tb/lpc_pwrctl_test.sv
module lpc_pwrctl_test;

  localparam int N_CHAN = 3;
  localparam int N_OPT = 4;
  localparam int W = 3 + N_CHAN + N_OPT;
  localparam int OPT_LSB = 3 + N_CHAN;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_rst_n = 1'b1;
  logic pwrdn_n = 1'b1;
  logic reg_we = 1'b0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic [2:0] lvl_state;
  logic iso_core;
  logic [N_OPT-1:0] iso_opt;
  logic lpc_init;

  int vectors = 0;
  int miscompares = 0;
  string phase = "R1";
  bit started = 0;

  // behavioural reference state
  logic [W-1:0] m_ctl = '0;
  int m_state = 5;
  bit m_iso = 0;
  logic [N_OPT-1:0] m_opt = '0;
  bit m_init = 0;
  bit h1 = 0, h2 = 0, p1 = 0, p2 = 0;
  int lv;
  logic [W-1:0] nc;

  always #4 clk = ~clk;

  lpc_pwrctl #(.N_CHAN(N_CHAN), .N_OPT(N_OPT)) uut (
    .clk(clk), .rst(rst), .host_rst_n(host_rst_n), .pwrdn_n(pwrdn_n),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .lvl_state(lvl_state), .iso_core(iso_core), .iso_opt(iso_opt),
    .lpc_init(lpc_init)
  );

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_ctl = '0; m_state = 5; m_iso = 0; m_opt = '0; m_init = 0;
      h1 = 0; h2 = 0; p1 = 0; p2 = 0;
    end else begin
      if (h2) lv = 4;
      else if (m_ctl[0]) lv = 3;
      else if (p2 && m_ctl[1]) lv = 2;
      else if (m_ctl[2]) lv = 1;
      else lv = 0;
      nc = reg_we ? reg_wdata : m_ctl;
      if (lv == 4) nc[2:0] = 3'b000;
      if (lv == 3) nc[2:1] = 2'b00;
      if (lv == 2) nc[2] = 1'b0;
      m_init = (lv > m_state);
      m_iso = (lv == 1 || lv == 2);
      m_opt = m_iso ? m_ctl[OPT_LSB +: N_OPT] : '0;
      m_state = lv;
      m_ctl = nc;
      h2 = h1; h1 = !host_rst_n;
      p2 = p1; p1 = !pwrdn_n;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s (%s, phase %s) at %0t: actual %0h expected %0h", req, what, phase, $time, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (started) begin
      check("R2", "reg_rdata", int'(reg_rdata), int'(m_ctl));
      check("R4", "lvl_state", int'(lvl_state), m_state);
      check("R9", "iso_core", int'(iso_core), int'(m_iso));
      check("R10", "iso_opt", int'(iso_opt), int'(m_opt));
      check("R11", "lpc_init", int'(lpc_init), int'(m_init));
    end
  endtask

  task automatic wr(input logic [W-1:0] d);
    reg_we = 1'b1; reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(8 * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R1: system reset state
    phase = "R1";
    idle(3);
    rst = 1'b0;
    idle(2);
    // R2: load channel and optional enables
    phase = "R2";
    wr(10'h3F8);
    idle(2);
    // R8, R10, R11: software shutdown with all optional enables
    phase = "R8";
    wr(10'h3FC);
    idle(3);
    phase = "R10";
    wr(10'h17C);
    idle(3);
    wr(10'h03C);
    idle(2);
    wr(10'h3F8);
    idle(2);
    // R7, R3: hardware shutdown via the power-down pin
    phase = "R7";
    wr(10'h3FA);
    pwrdn_n = 1'b0;
    idle(4);
    wr(10'h3FE);
    idle(2);
    // R12, R5: host reset during shutdown, writes lose to the clear
    phase = "R12";
    host_rst_n = 1'b0;
    idle(4);
    phase = "R5";
    wr(10'h3FF);
    idle(2);
    host_rst_n = 1'b1;
    idle(4);
    phase = "R3";
    pwrdn_n = 1'b1;
    idle(4);
    // R6: software reset clears enable and shutdown bits
    phase = "R6";
    wr(10'h3FF);
    idle(2);
    wr(10'h3FE);
    idle(2);
    wr(10'h3F8);
    idle(3);
    // R1 again mid-run
    phase = "R1";
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(2);
    // random mix of all levels
    phase = "R4";
    for (int i = 0; i < 4000; i++) begin
      rst = ($urandom_range(0, 499) == 0);
      if ($urandom_range(0, 39) == 0) host_rst_n = ~host_rst_n;
      if ($urandom_range(0, 19) == 0) pwrdn_n = ~pwrdn_n;
      reg_we = ($urandom_range(0, 3) == 0);
      reg_wdata = W'($urandom);
      if ($urandom_range(0, 1) == 0) reg_wdata[0] = 1'b0;
      step();
    end
    rst = 1'b0; reg_we = 1'b0;
    idle(4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule